// File: doc/BRIEF.md
# Dual-Rail Minterm Logic Gate

This block computes any boolean function of two or three logical inputs when each input is carried on a pair of wires. One wire is the true rail and the other is the false rail. A value becomes valid when exactly one rail of the pair goes high. The all-zero pair is the spacer that separates two data wavefronts in four-phase return-to-zero signalling. The gate builds one hysteresis cell for every combination of input rails. For each minterm, a cell sees one rail from every input and turns on only when all of those rails are high. It turns off only when all of them are low, and otherwise keeps its state. The outputs of the cells are then ORed into an output true rail or an output false rail, chosen by a truth-table parameter.

In this block each hysteresis cell is a clocked state element. A cell samples its rails on every clock edge. It sets when all of its rails are high, clears when all are low, and holds in every other case. As a result the output waits for the last input to arrive, and it keeps the result until the last input has gone back to spacer. The arrival order of the inputs does not matter. The number of inputs (2 or 3) and the truth table are parameters. Bit k of the truth table gives the output value when the input word equals k, where input i contributes bit i of k.

Top module: `dr_minterm_gate`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, every hysteresis cell is clear and both output rails are 0 (spacer).
- R2: When every input carries a valid codeword (exactly one of its rails high), exactly one output rail is high at the first clock edge after the last input became valid.
- R3: The output true rail is high exactly when bit k of the truth-table parameter is 1, where k is the input word. Bit i of k is 1 when input i has its true rail (in_t[i]) high, and 0 when it has its false rail (in_f[i]) high. Otherwise the output false rail is high.
- R4: While at least one input is still spacer, the output stays spacer, even when the other inputs already hold valid codewords.
- R5: Once the output is valid, it keeps its value while only some inputs have returned to spacer. It returns to spacer at the first clock edge after every input is spacer.
- R6: The two output rails are never high together, and at most one hysteresis cell is set at any time.
- R7: With three inputs the gate uses eight three-rail cells and meets R2 to R5 for all eight input words.
- R8: The output value does not depend on the order in which the inputs become valid or return to spacer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock of the hysteresis cells |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_t | input | N_IN | True rail of each logical input |
| in_f | input | N_IN | False rail of each logical input |
| out_t | output | 1 | Output true rail |
| out_f | output | 1 | Output false rail |

## Verification
Some internal faults can only be seen at the ports. A cell whose set condition is too weak shows up as an output that rises while one input is still spacer. It appears at the edge right after the partial wavefront is applied. A cell whose clear condition is too weak shows up as an output that falls while some inputs still hold data. That appears one cycle after the first input is withdrawn. A cell that is wired to the wrong rail, or a truth-table bit that is placed wrongly, shows up as a wrong output rail, or as both rails high. That appears at the first edge after the affected input word is complete. For this reason every word is applied both all at once and in staggered order, with a check after every step.

// File: rtl/dr_gate_pkg.sv
package dr_gate_pkg;

  localparam int unsigned MAX_INPUTS = 3;

  function automatic int unsigned minterm_count(input int unsigned n_inputs);
    return 32'd1 << n_inputs;
  endfunction

endpackage

// File: rtl/dr_rst_sync.sv
module dr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dr_hyst_cell.sv
module dr_hyst_cell #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rails,
  output logic             q
);

  logic all_hi;
  logic all_lo;
  logic upd_en;
  logic q_nxt;

  always_comb begin
    all_hi = &rails;
    all_lo = ~|rails;
    upd_en = all_hi | all_lo;
    q_nxt  = all_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (upd_en) q <= q_nxt;
  end

  AST_CELL_SET_ALL_HI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> $past(&rails)); // R4
  AST_CELL_CLR_ALL_LO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q) |-> $past(~|rails)); // R5

endmodule

// File: rtl/dr_minterm_row.sv
module dr_minterm_row #(
  parameter int N_IN = 2,
  localparam int CELLS = int'(dr_gate_pkg::minterm_count(N_IN))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  in_t,
  input  logic [N_IN-1:0]  in_f,
  output logic [CELLS-1:0] minterm
);

  for (genvar m = 0; m < CELLS; m++) begin : g_cell
    logic [N_IN-1:0] pick;

    always_comb begin
      for (int i = 0; i < N_IN; i++) begin
        pick[i] = (((m >> i) & 1) != 0) ? in_t[i] : in_f[i];
      end
    end

    dr_hyst_cell #(.WIDTH(N_IN)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .rails (pick),
      .q     (minterm[m])
    );
  end

  AST_ONE_MINTERM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(minterm)); // R6

endmodule

// File: rtl/dr_rail_merge.sv
module dr_rail_merge #(
  parameter int CELLS = 4,
  parameter logic [CELLS-1:0] TRUTH = '0
) (
  input  logic [CELLS-1:0] minterm,
  output logic             out_t,
  output logic             out_f
);

  logic [CELLS-1:0] to_true;
  logic [CELLS-1:0] to_false;

  for (genvar m = 0; m < CELLS; m++) begin : g_route
    if (TRUTH[m]) begin : g_one
      assign to_true[m]  = minterm[m];
      assign to_false[m] = 1'b0;
    end else begin : g_zero
      assign to_true[m]  = 1'b0;
      assign to_false[m] = minterm[m];
    end
  end

  assign out_t = |to_true;
  assign out_f = |to_false;

endmodule

// File: rtl/dr_minterm_gate.sv
module dr_minterm_gate #(
  parameter int N_IN = 2,
  parameter logic [(2**N_IN)-1:0] TRUTH = 4'b1011
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] in_t,
  input  logic [N_IN-1:0] in_f,
  output logic            out_t,
  output logic            out_f
);

  localparam int CELLS = int'(dr_gate_pkg::minterm_count(N_IN));

  logic             rst_n_sync;
  logic [CELLS-1:0] minterm;
  logic [N_IN-1:0]  in_valid;
  logic [N_IN-1:0]  in_spacer;

  assign in_valid  = in_t ^ in_f;
  assign in_spacer = ~(in_t | in_f);

  dr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dr_minterm_row #(.N_IN(N_IN)) u_row (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .in_t    (in_t),
    .in_f    (in_f),
    .minterm (minterm)
  );

  dr_rail_merge #(.CELLS(CELLS), .TRUTH(TRUTH)) u_merge (
    .minterm (minterm),
    .out_t   (out_t),
    .out_f   (out_f)
  );

  AST_INPUT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_t & in_f) == '0); // R2
  AST_RAILS_EXCL: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(out_t && out_f)); // R6
  AST_WAIT_ALL_VALID: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(out_t | out_f) |-> $past(&in_valid)); // R4
  AST_WAIT_ALL_SPACER: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $fell(out_t | out_f) |-> $past(&in_spacer)); // R5
  AST_VALUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(out_t) |-> $past(TRUTH[in_t])); // R3

endmodule

// File: tb/dr_minterm_gate_bench.sv
module dr_minterm_gate_bench;

  localparam logic [3:0] TT2 = 4'b1011;
  localparam logic [7:0] TT3 = 8'hD4;

  logic clk;
  logic rst_n;
  logic [1:0] a_t, a_f;
  logic [2:0] b_t, b_f;
  logic a_ot, a_of, b_ot, b_of;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  dr_minterm_gate #(.N_IN(2), .TRUTH(TT2)) u_dr_minterm_gate (
    .clk(clk), .rst_n(rst_n), .in_t(a_t), .in_f(a_f), .out_t(a_ot), .out_f(a_of));

  dr_minterm_gate #(.N_IN(3), .TRUTH(TT3)) u_dr_minterm_gate_3 (
    .clk(clk), .rst_n(rst_n), .in_t(b_t), .in_f(b_f), .out_t(b_ot), .out_f(b_of));

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rails(t,f) actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic legal_check(input string req);
    n_cmp++;
    if (((a_t & a_f) != 0) || ((b_t & b_f) != 0)) begin
      n_bad++;
      $display("FAIL %s: illegal codeword applied actual=%b%b expected=0", req, a_t & a_f, b_t & b_f);
    end
  endtask

  function automatic logic [1:0] exp2(input int k);
    return TT2[k] ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [1:0] exp3(input int k);
    return TT3[k] ? 2'b10 : 2'b01;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    a_t = '0; a_f = '0; b_t = '0; b_f = '0;
    repeat (3) @(negedge clk);
    chk("R1 during reset n2", {a_ot, a_of}, 2'b00);
    chk("R1 during reset n3", {b_ot, b_of}, 2'b00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release n2", {a_ot, a_of}, 2'b00);
    chk("R1 after release n3", {b_ot, b_of}, 2'b00);
  endtask

  task automatic t_burst2();
    for (int k = 0; k < 4; k++) begin
      a_t = k[1:0]; a_f = ~k[1:0];
      legal_check("R2 legal input");
      @(negedge clk);
      chk($sformatf("R2/R3 n2 word %0d", k), {a_ot, a_of}, exp2(k));
      n_cmp++;
      if (a_ot && a_of) begin
        n_bad++;
        $display("FAIL R6: both rails actual=11 expected=one-hot word %0d", k);
      end
      a_t = '0; a_f = '0;
      @(negedge clk);
      chk($sformatf("R5 n2 spacer after word %0d", k), {a_ot, a_of}, 2'b00);
    end
  endtask

  task automatic t_stagger2();
    for (int k = 0; k < 4; k++) begin
      for (int ord = 0; ord < 2; ord++) begin
        int first = ord;
        int second = 1 - ord;
        a_t[first] = k[first]; a_f[first] = ~k[first];
        @(negedge clk);
        chk($sformatf("R4 n2 partial word %0d order %0d", k, ord), {a_ot, a_of}, 2'b00);
        a_t[second] = k[second]; a_f[second] = ~k[second];
        @(negedge clk);
        chk($sformatf("R8 n2 word %0d order %0d", k, ord), {a_ot, a_of}, exp2(k));
        a_t[second] = 1'b0; a_f[second] = 1'b0;
        @(negedge clk);
        chk($sformatf("R5 n2 hold word %0d order %0d", k, ord), {a_ot, a_of}, exp2(k));
        a_t[first] = 1'b0; a_f[first] = 1'b0;
        @(negedge clk);
        chk($sformatf("R5 n2 release word %0d order %0d", k, ord), {a_ot, a_of}, 2'b00);
      end
    end
  endtask

  task automatic t_three();
    for (int k = 0; k < 8; k++) begin
      b_t = k[2:0]; b_f = ~k[2:0];
      legal_check("R7 legal input");
      @(negedge clk);
      chk($sformatf("R7 n3 burst word %0d", k), {b_ot, b_of}, exp3(k));
      b_t = '0; b_f = '0;
      @(negedge clk);
      chk($sformatf("R7 n3 spacer word %0d", k), {b_ot, b_of}, 2'b00);
      for (int i = 2; i >= 0; i--) begin
        b_t[i] = k[i]; b_f[i] = ~k[i];
        @(negedge clk);
        chk($sformatf("R4/R8 n3 rising word %0d step %0d", k, i), {b_ot, b_of},
            (i == 0) ? exp3(k) : 2'b00);
      end
      for (int i = 0; i < 3; i++) begin
        b_t[i] = 1'b0; b_f[i] = 1'b0;
        @(negedge clk);
        chk($sformatf("R5/R8 n3 falling word %0d step %0d", k, i), {b_ot, b_of},
            (i == 2) ? 2'b00 : exp3(k));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_burst2();
    t_stagger2();
    t_three();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule